// File: doc/BRIEF.md
# Sampling Converter Serial Output Port

This block is the digital side of an 18-bit sampling converter's serial port. A rising edge on the convert strobe starts an internal conversion timer. The same edge samples the serial input line to pick how the result will be read out. When the timer expires, an 18-bit two's-complement code is taken from a parallel stimulus port and placed in an output shift register. The host then clocks the code out, most significant bit first, with an external shift clock. The output advances on each falling edge of that clock.

Two read-out styles are supported. In select mode, the output driver is enabled only while the strobe or the serial input is held low. The driver releases after the last data bit has been shifted. If a select line is low when the conversion ends, a leading busy bit is sent first: the line is low during the conversion and goes high when the conversion finishes. In chain mode, the output is always driven and the serial input is fed into the bottom of the shift register. Several devices can then be cascaded on one data line. A new strobe edge that arrives while a conversion is running has no effect, apart from setting a sticky error flag.

All pins are sampled in the system clock domain. The conversion length is a parameter counted in system clock cycles.

Top module: `adc_serial_port`

## Requirements
- R1: At a rising edge of `conv_start` that starts a conversion, `ser_in` is sampled. A low level selects chain mode and a high level selects select mode. The mode then holds until the next conversion that is accepted.
- R2: The result register loads `sample_code` exactly CONV_CYCLES system clocks after the clock edge that detected the strobe rising edge, with no further delay. The value loaded is the one present at that completion edge. The code's bit 17 (the sign bit) appears on `ser_out` first.
- R3: In select mode, `ser_oe` is low whenever `conv_start` and `ser_in` are both high.
- R4: In select mode, `ser_oe` goes low after the falling edge of `shift_clk` that shifts out the last data bit. This is 18 falls after completion, or 19 falls when the busy bit was sent first.
- R5: Each falling edge of `shift_clk` outside a conversion moves the next lower bit of the code onto `ser_out`.
- R6: In select mode, `ser_out` is driven low while a conversion runs and the driver is enabled. If a select line is low at completion, `ser_out` reads 1 right after completion, and the first `shift_clk` fall brings out bit 17.
- R7: In chain mode, `ser_oe` stays high. The `ser_in` level sampled at a `shift_clk` fall appears on `ser_out` after the 18th fall counted from that one.
- R8: While a conversion runs, `shift_clk` falls do not change the shift register, so in chain mode `ser_out` holds its value.
- R9: A `conv_start` rising edge during an active conversion changes neither the mode nor the completion time. It sets `retrig_err`, which stays set until reset.
- R10: After reset, `ser_oe`, `ser_out` and `retrig_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Convert strobe; a rising edge starts a conversion; a low level acts as a select line in select mode |
| ser_in | input | 1 | Serial input: mode choice at the strobe edge, select line in select mode, cascade data in chain mode |
| shift_clk | input | 1 | External shift clock; data advances on its falling edge |
| sample_code | input | 18 | Two's-complement conversion code from the stimulus source |
| ser_out | output | 1 | Serial data output |
| ser_oe | output | 1 | Output driver enable (low means high impedance) |
| retrig_err | output | 1 | Sticky flag for a strobe edge seen during a conversion |

## Verification
A wrong mode bit shows up at once on `ser_oe`: chain mode keeps the driver on while select mode with both lines high turns it off. A miscounted conversion timer shifts the busy-to-high transition on `ser_out` by a whole number of cycles, and the bench samples that transition on the exact expected cycle. A corrupted shift register or bit counter shows up within one `shift_clk` pulse as a wrong data bit, or as the driver releasing one fall too early or too late. In chain mode, an off-by-one in the cascade path shows up 18 falls later.

// File: rtl/adc_sp_pkg.sv
// Package: shared types for the converter serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_sp_pkg;
    typedef enum logic {
        MODE_SELECT = 1'b0,
        MODE_CHAIN  = 1'b1
    } link_mode_t;
endpackage

// File: rtl/sig_edges.sv
// Module: sig_edges
// Detects one edge per input bit in the system clock domain. FALL_SEL chooses
// falling (1) or rising (0) detection per bit.
// Assumes: inputs are already synchronous to clk.
module sig_edges #(
    parameter int             N        = 2,
    parameter logic [N-1:0]   FALL_SEL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_q;

    // Keep last cycle's level of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        if (FALL_SEL[g]) begin : g_fall
            assign evt[g] = prev_q[g] & ~din[g];
        end else begin : g_rise
            assign evt[g] = ~prev_q[g] & din[g];
        end
    end
endmodule

// File: rtl/conv_timer.sv
// Module: conv_timer
// Counts a fixed conversion length after a start pulse. `done` is high in the
// last active cycle, when the result must be captured.
// Assumes: CYCLES >= 2; start is never raised while active.
module conv_timer #(
    parameter int CYCLES = 275
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CW = $clog2(CYCLES);

    logic [CW-1:0] cnt_q;
    logic          act_q;

    // Load the count on start and run it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= CW'(CYCLES - 1);
        end else if (act_q) begin
            if (cnt_q == '0) act_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = act_q;
    assign done   = act_q && (cnt_q == '0);
endmodule

// File: rtl/out_shifter.sv
// Module: out_shifter
// Output shift register with an optional leading busy bit. Shifts toward the
// MSB and takes new bits in at the LSB. Counts data bits so the caller knows
// when the word is used up.
// Assumes: load and shift_en are never high in the same cycle.
module out_shifter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         busy_arm,
    input  logic         shift_en,
    input  logic         din,
    input  logic [W-1:0] par_in,
    output logic         tx_bit,
    output logic         spent
);
    localparam int NW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [NW-1:0] cnt_q;
    logic          busy_q;

    // Capture a new word, or drop the busy bit, or shift one data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            busy_q <= 1'b0;
            cnt_q  <= NW'(W);
        end else if (load) begin
            sh_q   <= par_in;
            busy_q <= busy_arm;
            cnt_q  <= '0;
        end else if (shift_en) begin
            if (busy_q) begin
                busy_q <= 1'b0;
            end else begin
                sh_q <= {sh_q[W-2:0], din};
                if (cnt_q != NW'(W)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign tx_bit = busy_q ? 1'b1 : sh_q[W-1];
    assign spent  = (cnt_q == NW'(W));
endmodule

// File: rtl/adc_serial_port.sv
// Module: adc_serial_port (top)
// Serial port of a sampling converter: strobe edge starts a timed conversion
// and latches the read-out mode; the result is then shifted out on falling
// edges of an external shift clock in select mode or chain mode.
// Assumes: all pins are synchronous to clk; strobe low during reset.
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 275
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              ser_in,
    input  logic              shift_clk,
    input  logic [DATA_W-1:0] sample_code,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              retrig_err
);
    logic [1:0] evt;
    logic       strobe_rise, shift_fall;
    logic       conv_active, conv_done, accept;
    logic       tx_bit, spent, sel_low, chain_mode;
    link_mode_t mode_q;
    logic       err_q;

    sig_edges #(.N(2), .FALL_SEL(2'b10)) edges_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({shift_clk, conv_start}),
        .evt   (evt)
    );
    assign strobe_rise = evt[0];
    assign shift_fall  = evt[1];
    assign accept      = strobe_rise && !conv_active;

    conv_timer #(.CYCLES(CONV_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (accept),
        .active (conv_active),
        .done   (conv_done)
    );

    // Latch the read-out mode on an accepted strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MODE_SELECT;
        else if (accept) mode_q <= ser_in ? MODE_SELECT : MODE_CHAIN;
    end

    // Sticky flag for a strobe edge arriving mid-conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                           err_q <= 1'b0;
        else if (strobe_rise && conv_active) err_q <= 1'b1;
    end

    assign chain_mode = (mode_q == MODE_CHAIN);
    assign sel_low    = !conv_start || !ser_in;

    out_shifter #(.W(DATA_W)) shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_done),
        .busy_arm (!chain_mode && sel_low),
        .shift_en (shift_fall && !conv_active),
        .din      (ser_in),
        .par_in   (sample_code),
        .tx_bit   (tx_bit),
        .spent    (spent)
    );

    // Drive enable and data for the current mode.
    always_comb begin
        if (chain_mode) begin
            ser_oe  = 1'b1;
            ser_out = tx_bit;
        end else begin
            ser_oe  = sel_low && (conv_active || !spent);
            ser_out = conv_active ? 1'b0 : tx_bit;
        end
    end

    assign retrig_err = err_q;
endmodule

// File: rtl/adc_sp_checker.sv
// Module: adc_sp_checker
// Temporal properties of the serial port, bound into every adc_serial_port.
// Assumes: sampled on the system clock, disabled during reset.
module adc_sp_checker (
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic ser_in,
    input logic ser_out,
    input logic ser_oe,
    input logic retrig_err,
    input logic chain_mode,
    input logic conv_active
);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        retrig_err |=> retrig_err);

    a_r3_select_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_mode && conv_start && ser_in) |-> !ser_oe);

    a_r7_chain_driven: assert property (@(posedge clk) disable iff (!rst_n)
        chain_mode |-> ser_oe);

    a_r6_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && !chain_mode && ser_oe) |-> !ser_out);

    a_r8_hold_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && chain_mode) |=> (!conv_active || $stable(ser_out)));
endmodule

bind adc_serial_port adc_sp_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_start  (conv_start),
    .ser_in      (ser_in),
    .ser_out     (ser_out),
    .ser_oe      (ser_oe),
    .retrig_err  (retrig_err),
    .chain_mode  (chain_mode),
    .conv_active (conv_active)
);

// File: tb/adc_serial_port_tb_top.sv
`timescale 1ns/1ps
module adc_serial_port_tb_top;
    localparam int W    = 18;
    localparam int CONV = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_start = 1'b0;
    logic         ser_in = 1'b0;
    logic         shift_clk = 1'b0;
    logic [W-1:0] code = '0;
    logic         ser_out, ser_oe, retrig_err;

    int checks = 0;
    int errors = 0;
    int tk = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_start  (conv_start),
        .ser_in      (ser_in),
        .shift_clk   (shift_clk),
        .sample_code (code),
        .ser_out     (ser_out),
        .ser_oe      (ser_oe),
        .retrig_err  (retrig_err)
    );

    function automatic logic exp_bit(input logic [W-1:0] v, input int i);
        return v[W-1-i];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        tk++;
    endtask

    // Called at a negedge with conv_start low beforehand.
    task automatic start_conv(input logic lvl, input logic [W-1:0] v);
        code       = v;
        ser_in     = lvl;
        conv_start = 1'b1;
        tk         = 0;
    endtask

    task automatic sck_pulse(input logic din);
        shift_clk = 1'b1;
        tick();
        shift_clk = 1'b0;
        ser_in    = din;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v, v2, v3;
        logic [W+5:0] s;
        void'($urandom(32'h5A17));

        // R10 reset state
        repeat (3) tick();
        chk("R10 oe in reset", ser_oe, 0);
        chk("R10 err in reset", retrig_err, 0);
        chk("R10 out in reset", ser_out, 0);
        rst_n = 1'b1;
        tick();
        chk("R10 oe after reset", ser_oe, 0);

        // R1/R2/R3/R4/R5 select mode, no busy bit
        for (int n = 0; n < 4; n++) begin
            v = (n == 0) ? {1'b1, {(W-1){1'b0}}} : (n == 1) ? {1'b0, {(W-1){1'b1}}} : W'($urandom);
            ser_in = 1'b1;
            tick();
            start_conv(1'b1, v);
            tick();
            chk("R3 hiz during conv, both high", ser_oe, 0);
            while (tk < CONV + 1) tick();
            chk("R3 hiz after conv, both high", ser_oe, 0);
            conv_start = 1'b0;
            tick();
            chk("R1 select mode drives on low strobe", ser_oe, 1);
            chk("R2 msb first", ser_out, exp_bit(v, 0));
            for (int i = 1; i < W; i++) begin
                sck_pulse(1'b1);
                chk("R5 select bit", ser_out, exp_bit(v, i));
                chk("R4 still driven", ser_oe, 1);
            end
            sck_pulse(1'b1);
            chk("R4 release after last bit", ser_oe, 0);
        end

        // R6 busy bit: variant 0 strobe low, variant 1 serial input low
        for (int n = 0; n < 2; n++) begin
            v = W'($urandom);
            conv_start = 1'b0;
            ser_in = 1'b1;
            tick();
            start_conv(1'b1, v);
            tick();
            if (n == 0) conv_start = 1'b0;
            else        ser_in = 1'b0;
            tick();
            chk("R6 driven during conv", ser_oe, 1);
            chk("R6 low during conv", ser_out, 0);
            while (tk < CONV) tick();
            chk("R6 still low last conv cycle", ser_out, 0);
            tick();
            chk("R2 busy bit high at completion", ser_out, 1);
            for (int i = 0; i < W; i++) begin
                sck_pulse(ser_in);
                chk("R6 data after busy bit", ser_out, exp_bit(v, i));
            end
            chk("R4 driven through last bit", ser_oe, 1);
            sck_pulse(ser_in);
            chk("R4 release after busy read", ser_oe, 0);
            conv_start = 1'b0;
            ser_in = 1'b1;
            tick();
        end

        // R7 chain mode pass-through
        v = W'($urandom);
        conv_start = 1'b0;
        tick();
        start_conv(1'b0, v);
        tick();
        ser_in = 1'b1;
        tick();
        chk("R7 chain oe during conv", ser_oe, 1);
        while (tk < CONV + 1) tick();
        chk("R2 chain msb", ser_out, exp_bit(v, 0));
        s = '0;
        for (int k = 1; k <= W + 4; k++) begin
            s[k] = 1'($urandom);
            sck_pulse(s[k]);
            if (k < W) chk("R5 chain bit", ser_out, exp_bit(v, k));
            else       chk("R7 chain delayed input", ser_out, s[k-W+1]);
            chk("R7 chain oe", ser_oe, 1);
        end

        // R8 hold during conversion; R2 capture at completion
        v2 = W'($urandom);
        conv_start = 1'b0;
        tick();
        start_conv(1'b0, v2);
        while (tk < CONV + 1) tick();
        conv_start = 1'b0;
        for (int i = 0; i < 3; i++) sck_pulse(1'b0);
        chk("R5 after three shifts", ser_out, exp_bit(v2, 3));
        tick();
        start_conv(1'b0, ~v2);
        tick();
        v3 = W'($urandom);
        code = v3;
        for (int i = 0; i < 3; i++) begin
            sck_pulse(1'($urandom));
            chk("R8 held during conv", ser_out, exp_bit(v2, 3));
        end
        while (tk < CONV + 1) tick();
        chk("R2 value taken at completion", ser_out, exp_bit(v3, 0));

        // R9 retrigger ignored, sticky error
        v = W'($urandom);
        conv_start = 1'b0;
        ser_in = 1'b1;
        tick();
        chk("R9 no error yet", retrig_err, 0);
        start_conv(1'b1, v);
        tick();
        conv_start = 1'b0;
        tick();
        ser_in = 1'b0;
        conv_start = 1'b1;
        tick();
        chk("R9 error set", retrig_err, 1);
        ser_in = 1'b1;
        tick();
        chk("R9 mode unchanged", ser_oe, 0);
        conv_start = 1'b0;
        tick();
        chk("R9 busy low", ser_out, 0);
        while (tk < CONV) tick();
        chk("R9 completion not moved (busy)", ser_out, 0);
        tick();
        chk("R9 completion on time", ser_out, 1);
        sck_pulse(1'b1);
        chk("R9 data intact", ser_out, exp_bit(v, 0));
        repeat (5) tick();
        chk("R9 error sticky", retrig_err, 1);
        rst_n = 1'b0;
        conv_start = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        chk("R10 error cleared by reset", retrig_err, 0);
        chk("R10 oe cleared by reset", ser_oe, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule